// File: doc/BRIEF.md
# Flash command sequence interpreter

This block sits on the device side of a byte-wide NOR flash and decodes the host's write cycles. Each write cycle is an address and a data byte, qualified by a one-cycle strobe. Multi-cycle unlock sequences are turned into one-cycle requests to an embedded-operation engine: byte program, chip erase, sector erase, erase suspend and erase resume. The block also enters and leaves the identifier-read mode and honours the single-write reset command.

The interpreter keeps the device mode and steers every read to one of three sources: the array, the identifier and protection codes, or the engine's status byte. The engine answers each program or erase with a one-cycle done pulse. Protection of each group of four adjacent sectors arrives as a bit vector. Any program or sector erase that targets a protected group is dropped before it reaches the engine.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of any operation, the mode is read (0) and no request output is high.
- R2: The four writes AAh@555h, 55h@2AAh, A0h@555h and then data@address raise `req_prog` for one cycle after the last write. The same edge latches `req_addr` and `req_data` and sets the mode to 2. An `eng_done` pulse returns the mode to 0. Command addresses compare only the low 11 address bits.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h and 55h@2AAh, followed by 10h@555h, raise `req_chip` and set mode 3. Followed instead by 30h at any address, they raise `req_sect` for the sector given by address bits 20:16 and set mode 4.
- R4: A write with the wrong address or data at any step of a sequence, or a write out of order, returns the mode to read (0) and issues no request.
- R5: A program or sector erase whose target lies in a protected group issues no request and leaves the mode unchanged. The group is the sector number divided by four, and group g is protected when `grp_prot[g]` is 1.
- R6: In mode 4, a B0h write at any address raises `req_susp` and sets mode 5. A B0h write in modes 0, 2, 3 or 6 changes nothing.
- R7: In mode 5, a 30h write at any address raises `req_resume` and sets mode 4. Outside mode 5, a lone 30h write issues no resume.
- R8: In mode 5, a program sequence to a sector other than the one being erased raises `req_prog` and sets mode 6, and `eng_done` returns the mode to 5. In mode 5, a program to the erasing sector, an erase set-up and a repeated B0h are all ignored, and the mode stays 5.
- R9: In modes 2, 3 and 6, and in mode 4 for anything other than B0h, writes change neither the mode nor the requests.
- R10: The sequence AAh@555h, 55h@2AAh, 90h@555h sets mode 1. In mode 1 a read at low address byte 00h returns 04h, at 01h returns ADh, at 02h returns 01h or 00h as the protection bit of the addressed group, and at any other low byte returns 00h. A write of F0h returns the mode to 0.
- R11: In mode 0, reads return `array_rdata`. In modes 2, 3, 4 and 6 they return `eng_status`. In mode 5 they return `eng_status` for the sector being erased and `array_rdata` for any other sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also aborts any operation |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | 21 | Write address |
| wr_data | input | 8 | Write data |
| eng_done | input | 1 | Engine completion pulse |
| eng_status | input | 8 | Engine status byte |
| grp_prot | input | 8 | Protection bit per sector group |
| rd_addr | input | 21 | Read address |
| array_rdata | input | 8 | Array read data |
| rd_data | output | 8 | Steered read data |
| mode | output | 3 | Mode: 0 read, 1 autoselect, 2 program, 3 chip erase, 4 sector erase, 5 suspend-read, 6 suspend-program |
| req_prog | output | 1 | Byte program request pulse |
| req_chip | output | 1 | Chip erase request pulse |
| req_sect | output | 1 | Sector erase request pulse |
| req_susp | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_addr | output | 21 | Address latched with the request |
| req_data | output | 8 | Data latched with the request |

## Verification
The hardest case to reach is a program issued while a sector erase is suspended. The stimulus must first complete a six-write sector erase, then suspend it with B0h, and then run a complete four-write program sequence. That sequence is sent twice: once aimed at the erasing sector, where it must be refused, and once at a different sector, where it must be accepted. The engine's done pulse must then return the device to suspend-read rather than to read mode. The table walk follows this whole path, including an erase set-up that is ignored while suspended. The directed tests then confirm that reads are steered by sector during the suspension.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ    = 3'd0,
    M_AUTOSEL = 3'd1,
    M_BUSY_PG = 3'd2,
    M_BUSY_CE = 3'd3,
    M_BUSY_SE = 3'd4,
    M_SUSP_RD = 3'd5,
    M_SUSP_PG = 3'd6
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_UNLK, S_SETUP, S_PDATA, S_EUNLK1, S_EUNLK2, S_ECMD
  } seq_t;

  localparam logic [7:0] C_UNLK1  = 8'hAA;
  localparam logic [7:0] C_UNLK2  = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERASE  = 8'h80;
  localparam logic [7:0] C_AUTO   = 8'h90;
  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'h30;
  localparam logic [7:0] ID_MFR   = 8'h04;
  localparam logic [7:0] ID_DEV   = 8'hAD;

endpackage

// File: rtl/nor_grp_prot.sv
module nor_grp_prot #(
  parameter int SECT_W    = 5,
  parameter int GRP_SHIFT = 2,
  parameter int NPORT     = 3
) (
  input  logic [(1<<(SECT_W-GRP_SHIFT))-1:0] grp_prot,
  input  logic [NPORT-1:0][SECT_W-1:0]        sect,
  output logic [NPORT-1:0]                    prot
);
  localparam int GRP_W = SECT_W - GRP_SHIFT;

  function automatic logic [GRP_W-1:0] grp_of(input logic [SECT_W-1:0] s);
    return s[SECT_W-1:GRP_SHIFT];
  endfunction

  logic [NPORT-1:0][GRP_SHIFT-1:0] unused_low;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign prot[g]       = grp_prot[grp_of(sect[g])];
    assign unused_low[g] = sect[g][GRP_SHIFT-1:0];
  end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 5,
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_prot,
  input  logic              eng_done,
  output mode_t             mode,
  output logic [SECT_W-1:0] erase_sect,
  output logic              req_prog,
  output logic              req_chip,
  output logic              req_sect,
  output logic              req_susp,
  output logic              req_resume,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data
);
  localparam logic [CMD_AW-1:0] A_FIRST  = CMD_AW'('h555);
  localparam logic [CMD_AW-1:0] A_SECOND = CMD_AW'('h2AA);

  function automatic logic hit(input logic [CMD_AW-1:0] a, input logic [7:0] d,
                               input logic [CMD_AW-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  seq_t              seq, n_seq;
  mode_t             n_mode;
  logic [SECT_W-1:0] n_esect;
  logic [4:0]        n_req;
  logic              latch;

  logic [CMD_AW-1:0] w_lo;
  logic [SECT_W-1:0] w_sect;
  logic              susp, eng_busy;
  mode_t             fail_mode;

  assign w_lo      = wr_addr[CMD_AW-1:0];
  assign w_sect    = wr_addr[ADDR_W-1 -: SECT_W];
  assign susp      = (mode == M_SUSP_RD);
  assign fail_mode = susp ? M_SUSP_RD : M_READ;
  assign eng_busy  = mode inside {M_BUSY_PG, M_BUSY_CE, M_BUSY_SE, M_SUSP_PG};

  always_comb begin
    n_mode  = mode;
    n_seq   = seq;
    n_esect = erase_sect;
    n_req   = '0;
    latch   = 1'b0;
    if (eng_done && eng_busy) begin
      n_mode = (mode == M_SUSP_PG) ? M_SUSP_RD : M_READ;
    end else if (wr_stb) begin
      case (mode)
        M_READ, M_AUTOSEL, M_SUSP_RD: begin
          n_seq = S_IDLE;
          case (seq)
            S_IDLE: begin
              if (hit(w_lo, wr_data, A_FIRST, C_UNLK1)) n_seq = S_UNLK;
              else if (susp && wr_data == C_RESUME) begin
                n_mode = M_BUSY_SE;
                n_req  = 5'b00001;
              end else n_mode = fail_mode;
            end
            S_UNLK: begin
              if (hit(w_lo, wr_data, A_SECOND, C_UNLK2)) n_seq = S_SETUP;
              else n_mode = fail_mode;
            end
            S_SETUP: begin
              if (hit(w_lo, wr_data, A_FIRST, C_PROG)) n_seq = S_PDATA;
              else if (!susp && hit(w_lo, wr_data, A_FIRST, C_ERASE)) n_seq = S_EUNLK1;
              else if (!susp && hit(w_lo, wr_data, A_FIRST, C_AUTO)) n_mode = M_AUTOSEL;
              else n_mode = fail_mode;
            end
            S_PDATA: begin
              if (!wr_prot && !(susp && w_sect == erase_sect)) begin
                n_mode = susp ? M_SUSP_PG : M_BUSY_PG;
                n_req  = 5'b10000;
                latch  = 1'b1;
              end else n_mode = fail_mode;
            end
            S_EUNLK1: begin
              if (hit(w_lo, wr_data, A_FIRST, C_UNLK1)) n_seq = S_EUNLK2;
              else n_mode = M_READ;
            end
            S_EUNLK2: begin
              if (hit(w_lo, wr_data, A_SECOND, C_UNLK2)) n_seq = S_ECMD;
              else n_mode = M_READ;
            end
            S_ECMD: begin
              if (hit(w_lo, wr_data, A_FIRST, C_CHIP)) begin
                n_mode = M_BUSY_CE;
                n_req  = 5'b01000;
                latch  = 1'b1;
              end else if (wr_data == C_SECT && !wr_prot) begin
                n_mode  = M_BUSY_SE;
                n_req   = 5'b00100;
                n_esect = w_sect;
                latch   = 1'b1;
              end else n_mode = M_READ;
            end
            default: n_mode = M_READ;
          endcase
        end
        M_BUSY_SE: begin
          if (wr_data == C_SUSP) begin
            n_mode = M_SUSP_RD;
            n_req  = 5'b00010;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_READ;
      seq        <= S_IDLE;
      erase_sect <= '0;
      {req_prog, req_chip, req_sect, req_susp, req_resume} <= '0;
      req_addr   <= '0;
      req_data   <= '0;
    end else begin
      mode       <= n_mode;
      seq        <= n_seq;
      erase_sect <= n_esect;
      {req_prog, req_chip, req_sect, req_susp, req_resume} <= n_req;
      if (latch) begin
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end

  // R2
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_prog, req_chip, req_sect, req_susp, req_resume}));
  // R6
  susp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_susp |-> ($past(mode) == M_BUSY_SE) && (mode == M_SUSP_RD));
  // R7
  resume_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_resume |-> ($past(mode) == M_SUSP_RD) && (mode == M_BUSY_SE));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BUSY_PG && !eng_done) |=> (mode == M_BUSY_PG));
  // R8
  susp_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prog && mode == M_SUSP_PG) |-> (req_addr[ADDR_W-1 -: SECT_W] != erase_sect));
endmodule

// File: rtl/nor_rd_steer.sv
module nor_rd_steer
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 5,
  parameter int ID_AW  = 8
) (
  input  mode_t             mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SECT_W-1:0] erase_sect,
  input  logic              rd_prot,
  input  logic [7:0]        array_rdata,
  input  logic [7:0]        eng_status,
  output logic [7:0]        rd_data
);
  logic [ID_AW-1:0]  id_lo;
  logic [SECT_W-1:0] rd_sect;
  logic              unused_mid;

  assign id_lo      = rd_addr[ID_AW-1:0];
  assign rd_sect    = rd_addr[ADDR_W-1 -: SECT_W];
  assign unused_mid = ^rd_addr[ADDR_W-SECT_W-1:ID_AW];

  always_comb begin
    case (mode)
      M_READ:    rd_data = array_rdata;
      M_AUTOSEL: begin
        case (id_lo)
          ID_AW'(0): rd_data = ID_MFR;
          ID_AW'(1): rd_data = ID_DEV;
          ID_AW'(2): rd_data = {7'b0, rd_prot};
          default:   rd_data = 8'h00;
        endcase
      end
      M_SUSP_RD: rd_data = (rd_sect == erase_sect) ? eng_status : array_rdata;
      default:   rd_data = eng_status;
    endcase
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int SECT_W    = 5,
  parameter int GRP_SHIFT = 2,
  parameter int CMD_AW    = 11,
  parameter int ID_AW     = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_stb,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [7:0]                          wr_data,
  input  logic                                eng_done,
  input  logic [7:0]                          eng_status,
  input  logic [(1<<(SECT_W-GRP_SHIFT))-1:0]  grp_prot,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic [7:0]                          array_rdata,
  output logic [7:0]                          rd_data,
  output logic [2:0]                          mode,
  output logic                                req_prog,
  output logic                                req_chip,
  output logic                                req_sect,
  output logic                                req_susp,
  output logic                                req_resume,
  output logic [ADDR_W-1:0]                   req_addr,
  output logic [7:0]                          req_data
);
  localparam int NPORT = 3;

  mode_t                    mode_q;
  logic [SECT_W-1:0]        erase_sect;
  logic [NPORT-1:0][SECT_W-1:0] look_sect;
  logic [NPORT-1:0]         look_prot;
  logic                     wr_prot, rd_prot, req_prot;

  assign look_sect[0] = wr_addr[ADDR_W-1 -: SECT_W];
  assign look_sect[1] = rd_addr[ADDR_W-1 -: SECT_W];
  assign look_sect[2] = req_addr[ADDR_W-1 -: SECT_W];
  assign wr_prot  = look_prot[0];
  assign rd_prot  = look_prot[1];
  assign req_prot = look_prot[2];

  nor_grp_prot #(.SECT_W(SECT_W), .GRP_SHIFT(GRP_SHIFT), .NPORT(NPORT)) u_prot (
    .grp_prot (grp_prot),
    .sect     (look_sect),
    .prot     (look_prot)
  );

  nor_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CMD_AW(CMD_AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_prot    (wr_prot),
    .eng_done   (eng_done),
    .mode       (mode_q),
    .erase_sect (erase_sect),
    .req_prog   (req_prog),
    .req_chip   (req_chip),
    .req_sect   (req_sect),
    .req_susp   (req_susp),
    .req_resume (req_resume),
    .req_addr   (req_addr),
    .req_data   (req_data)
  );

  nor_rd_steer #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .ID_AW(ID_AW)) u_rd (
    .mode        (mode_q),
    .rd_addr     (rd_addr),
    .erase_sect  (erase_sect),
    .rd_prot     (rd_prot),
    .array_rdata (array_rdata),
    .eng_status  (eng_status),
    .rd_data     (rd_data)
  );

  assign mode = mode_q;

  // R5
  prot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prog || req_sect) |-> !req_prot);
  // R1
  idle_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_READ && !$past(wr_stb)) |-> (mode_q == M_READ));
endmodule

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        eng_done = 1'b0;
  logic [7:0]  eng_status = 8'h88;
  logic [7:0]  grp_prot = 8'b0000_0100;
  logic [20:0] rd_addr = '0;
  logic [7:0]  array_rdata = 8'h5A;
  logic [7:0]  rd_data;
  logic [2:0]  mode;
  logic        req_prog, req_chip, req_sect, req_susp, req_resume;
  logic [20:0] req_addr;
  logic [7:0]  req_data;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_done(eng_done), .eng_status(eng_status), .grp_prot(grp_prot),
    .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data), .mode(mode),
    .req_prog(req_prog), .req_chip(req_chip), .req_sect(req_sect), .req_susp(req_susp),
    .req_resume(req_resume), .req_addr(req_addr), .req_data(req_data)
  );

  // entry: {tag[3:0], done, addr[20:0], data[7:0], mode[2:0], req{prog,chip,sect,susp,resume}}
  function automatic logic [41:0] w(input logic [3:0] t, input logic [20:0] a,
                                    input logic [7:0] d, input logic [2:0] m, input logic [4:0] r);
    return {t, 1'b0, a, d, m, r};
  endfunction
  function automatic logic [41:0] dn(input logic [3:0] t, input logic [2:0] m);
    return {t, 1'b1, 21'h0, 8'h0, m, 5'b0};
  endfunction

  localparam int NV = 63;
  localparam logic [41:0] VEC [NV] = '{
    // R2 program sector 0, R9 busy ignores, R6 suspend ignored in program
    w(2, 21'h555, 8'hAA, 0, 0), w(2, 21'h2AA, 8'h55, 0, 0), w(2, 21'h555, 8'hA0, 0, 0),
    w(2, 21'h000100, 8'h12, 2, 5'b10000), w(9, 21'h555, 8'hAA, 2, 0),
    w(6, 21'h000000, 8'hB0, 2, 0), dn(2, 0),
    // R5 program into protected group 2
    w(5, 21'h555, 8'hAA, 0, 0), w(5, 21'h2AA, 8'h55, 0, 0), w(5, 21'h555, 8'hA0, 0, 0),
    w(5, 21'h090000, 8'h34, 0, 0),
    // R4 wrong second unlock
    w(4, 21'h555, 8'hAA, 0, 0), w(4, 21'h2AA, 8'h56, 0, 0), w(4, 21'h555, 8'hA0, 0, 0),
    w(4, 21'h000100, 8'h12, 0, 0),
    // R10 autoselect enter and leave
    w(10, 21'h555, 8'hAA, 0, 0), w(10, 21'h2AA, 8'h55, 0, 0), w(10, 21'h555, 8'h90, 1, 0),
    w(10, 21'h000000, 8'hF0, 0, 0),
    // R3 chip erase, R6 suspend ignored
    w(3, 21'h555, 8'hAA, 0, 0), w(3, 21'h2AA, 8'h55, 0, 0), w(3, 21'h555, 8'h80, 0, 0),
    w(3, 21'h555, 8'hAA, 0, 0), w(3, 21'h2AA, 8'h55, 0, 0), w(3, 21'h555, 8'h10, 3, 5'b01000),
    w(6, 21'h000000, 8'hB0, 3, 0), dn(3, 0),
    // R3 sector erase of sector 3, R9, R6, R8
    w(3, 21'h555, 8'hAA, 0, 0), w(3, 21'h2AA, 8'h55, 0, 0), w(3, 21'h555, 8'h80, 0, 0),
    w(3, 21'h555, 8'hAA, 0, 0), w(3, 21'h2AA, 8'h55, 0, 0), w(3, 21'h030000, 8'h30, 4, 5'b00100),
    w(9, 21'h555, 8'hAA, 4, 0), w(6, 21'h000123, 8'hB0, 5, 5'b00010),
    w(8, 21'h000000, 8'hB0, 5, 0),
    // R8 program to erasing sector refused
    w(8, 21'h555, 8'hAA, 5, 0), w(8, 21'h2AA, 8'h55, 5, 0), w(8, 21'h555, 8'hA0, 5, 0),
    w(8, 21'h030010, 8'h77, 5, 0),
    // R8 program to another sector accepted
    w(8, 21'h555, 8'hAA, 5, 0), w(8, 21'h2AA, 8'h55, 5, 0), w(8, 21'h555, 8'hA0, 5, 0),
    w(8, 21'h1F0000, 8'h77, 6, 5'b10000), dn(8, 5),
    // R8 erase set-up ignored while suspended
    w(8, 21'h555, 8'hAA, 5, 0), w(8, 21'h2AA, 8'h55, 5, 0), w(8, 21'h555, 8'h80, 5, 0),
    // R7 resume
    w(7, 21'h000000, 8'h30, 4, 5'b00001), dn(7, 0),
    // R5 sector erase into protected group
    w(5, 21'h555, 8'hAA, 0, 0), w(5, 21'h2AA, 8'h55, 0, 0), w(5, 21'h555, 8'h80, 0, 0),
    w(5, 21'h555, 8'hAA, 0, 0), w(5, 21'h2AA, 8'h55, 0, 0), w(5, 21'h0A0000, 8'h30, 0, 0),
    // R4 bad final erase code
    w(4, 21'h555, 8'hAA, 0, 0), w(4, 21'h2AA, 8'h55, 0, 0), w(4, 21'h555, 8'h80, 0, 0),
    w(4, 21'h555, 8'hAA, 0, 0), w(4, 21'h2AA, 8'h55, 0, 0), w(4, 21'h000555, 8'h20, 0, 0),
    // R7 lone resume in read mode ignored
    w(7, 21'h000000, 8'h30, 0, 0)
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    #1;
  endtask

  task automatic do_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    #1;
  endtask

  task automatic unlock3(input logic [7:0] setup);
    do_write(21'h555, 8'hAA);
    do_write(21'h2AA, 8'h55);
    do_write(21'h555, setup);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 mode", 32'(mode), 0);
    check("R1 reqs", 32'({req_prog, req_chip, req_sect, req_susp, req_resume}), 0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  t;
      logic        k;
      logic [20:0] a;
      logic [7:0]  d;
      logic [2:0]  m;
      logic [4:0]  r;
      string       tg;
      {t, k, a, d, m, r} = VEC[i];
      tg = $sformatf("R%0d step %0d", t, i);
      if (k) do_done();
      else   do_write(a, d);
      check({tg, " mode"}, 32'(mode), 32'(m));
      check({tg, " req"}, 32'({req_prog, req_chip, req_sect, req_susp, req_resume}), 32'(r));
      if (r[4] || r[3] || r[2]) check({tg, " req_addr"}, 32'(req_addr), 32'(a));
      if (r[4]) check({tg, " req_data"}, 32'(req_data), 32'(d));
    end

    // R11 read mode steering
    rd_addr = 21'h000040; #1;
    check("R11 read array", 32'(rd_data), 32'h5A);

    // R10 identifier reads
    unlock3(8'h90);
    check("R10 mode", 32'(mode), 1);
    rd_addr = 21'h000000; #1; check("R10 mfr", 32'(rd_data), 32'h04);
    rd_addr = 21'h000001; #1; check("R10 dev", 32'(rd_data), 32'hAD);
    rd_addr = 21'h080002; #1; check("R10 prot grp2", 32'(rd_data), 32'h01);
    rd_addr = 21'h1C0002; #1; check("R10 prot grp7", 32'(rd_data), 32'h00);
    rd_addr = 21'h000003; #1; check("R10 other", 32'(rd_data), 32'h00);
    do_write(21'h000000, 8'hF0);
    check("R10 exit", 32'(mode), 0);

    // R11 busy status, R1 reset aborts program
    unlock3(8'hA0);
    do_write(21'h010000, 8'h3C);
    check("R2 busy", 32'(mode), 2);
    rd_addr = 21'h010000; #1;
    check("R11 busy status", 32'(rd_data), 32'h88);
    pulse_reset();
    check("R1 abort mode", 32'(mode), 0);
    check("R1 abort rd", 32'(rd_data), 32'h5A);

    // R11 suspend steering by sector
    unlock3(8'h80);
    unlock3(8'h55);
    check("R4 bad erase unlock", 32'(mode), 0);
    unlock3(8'h80);
    do_write(21'h555, 8'hAA);
    do_write(21'h2AA, 8'h55);
    do_write(21'h040000, 8'h30);
    check("R3 sect4", 32'(mode), 4);
    do_write(21'h000000, 8'hB0);
    check("R6 suspend", 32'(mode), 5);
    rd_addr = 21'h04ABCD; #1;
    check("R11 susp erasing", 32'(rd_data), 32'h88);
    rd_addr = 21'h050000; #1;
    check("R11 susp other", 32'(rd_data), 32'h5A);
    pulse_reset();
    check("R1 abort suspend", 32'(mode), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule